// File: doc/BRIEF.md
# Return-to-Zero Avionics Word Receiver

This block takes in a serial avionics data word sent as a three-level return-to-zero signal. A line comparator turns that signal into two digital inputs. One input is high while the line is driven positive, which means a one. The other is high while the line is driven negative, which means a zero. When both are low, the line is at null. Every bit cell starts with a driven phase and ends with a return to null. The receiver takes its bit timing from those two edges in each cell and does not use a free-running bit clock.

The inputs first pass through a two-stage synchronizer. A cell-level state machine then checks that each driven level holds for long enough before it accepts a bit. The same machine detects long null gaps and line faults. A word-level state machine places the accepted bits into a 32-bit word. The first eight bits received are the label octet, which is sent most significant bit first. The remaining 24 bits arrive in ascending order. When the word is complete, the block checks odd parity and reports the word with a one-cycle strobe. The label octet can be presented either in natural bit numbering or bit-reversed.

Cell machine states: `CELL_NULL` (line quiet, null time counted), `CELL_QUAL` (driven level being qualified), `CELL_HOLD` (bit accepted, waiting for the return to null), `CELL_FAULT` (both inputs seen high, waiting for the line to go quiet). Its transitions are:
- null to qual on a single driven level
- qual to hold when the level is qualified
- qual to null on a glitch
- hold to null on the trailing edge
- any state to fault when both inputs are high
- fault to null when the line is quiet

Word machine states: `ASM_IDLE` (no bits held), `ASM_COLLECT` (between 1 and 31 bits held), `ASM_DISCARD` (word aborted, waiting for a gap). Its transitions are:
- idle to collect on the first bit
- collect to idle on the 32nd bit (word emitted) or on a gap (length error)
- any state to discard on a line fault
- discard to idle on a gap

Top module: `rz429_word_rx`

## Requirements
- R1: A bit is a one when only `line_hi` is high and a zero when only `line_lo` is high. When both are low, the line is null.
- R2: The first eight accepted bits of a word are word bits 8, 7, … , 1 in that order. With `label_as_sent` = 0, `word_data[i]` holds word bit i+1 for every i from 0 to 31.
- R3: The 9th through 32nd accepted bits are word bits 9 through 32 in ascending order, and they appear at `word_data[8]` through `word_data[31]`.
- R4: With `label_as_sent` = 1, `word_data[7:0]` is the bit-reverse of the natural label octet. `word_data[0]` then holds the first bit received. `word_data[31:8]` is unchanged.
- R5: `parity_error` is high together with `word_valid` exactly when the number of ones across all 32 word bits is even. It is never high without `word_valid`.
- R6: `word_valid` pulses for one clock right after the 32nd bit is accepted, without waiting for a gap. Two words sent back to back with no gap are both reported.
- R7: A driven level is accepted as a bit only if it is seen for at least `MIN_STABLE` (default 3) consecutive synchronized samples. A shorter pulse inside a null phase is ignored and leaves the word intact.
- R8: After the line has been null for 2×`BIT_CLKS` clocks, the bit count restarts. If 1 to 31 bits were held at that point, `length_error` pulses for one clock and `word_valid` stays low.
- R9: Both inputs high together pulses `line_error` and aborts the current word. All bits are then ignored until the next gap. That gap produces neither `word_valid` nor `length_error`.
- R10: A driven level counts as at most one bit, however long it is held, until the line returns to null.
- R11: While `rst_n` is low, `word_valid`, `parity_error`, `length_error` and `line_error` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_hi | input | 1 | Comparator output, high while the line is driven positive (one) |
| line_lo | input | 1 | Comparator output, high while the line is driven negative (zero) |
| label_as_sent | input | 1 | 1 = present the label octet bit-reversed, in transmission order |
| word_valid | output | 1 | One-clock strobe for a completed word |
| word_data | output | 32 | Received word; holds its value between strobes |
| parity_error | output | 1 | Even number of ones in the word; valid with `word_valid` |
| length_error | output | 1 | One-clock pulse: a gap ended a word that had fewer than 32 bits |
| line_error | output | 1 | One-clock pulse: both comparator inputs were seen high |

## Verification
The cell assertions assume that the driven phase of each cell is at least `MIN_STABLE` synchronized samples long. They also assume that the null phase inside a word is much shorter than the 2×`BIT_CLKS` gap threshold, so a gap can only fall between words. The stimulus therefore drives every cell as half `BIT_CLKS` high or low followed by half `BIT_CLKS` null. Between words it leaves the line null for three bit times. Deliberate violations are limited to a two-clock pulse inside a null phase, a level held for three bit times, and a single overlap of both inputs. Each of these has its own expected outcome.

// File: rtl/rz429_pkg.sv
package rz429_pkg;

    localparam int WORD_BITS  = 32;
    localparam int LABEL_BITS = 8;

    typedef enum logic [1:0] {
        CELL_NULL,
        CELL_QUAL,
        CELL_HOLD,
        CELL_FAULT
    } cell_state_t;

    typedef enum logic [1:0] {
        ASM_IDLE,
        ASM_COLLECT,
        ASM_DISCARD
    } asm_state_t;

    function automatic logic [LABEL_BITS-1:0] flip_octet(input logic [LABEL_BITS-1:0] v);
        logic [LABEL_BITS-1:0] r;
        for (int i = 0; i < LABEL_BITS; i++) begin
            r[i] = v[LABEL_BITS-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/rz429_sync.sv
module rz429_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN_W-WIDTH-1:0], din};
        end
    end

    assign dout = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/rz429_cell.sv
module rz429_cell
    import rz429_pkg::*;
#(
    parameter int BIT_CLKS   = 500,
    parameter int MIN_STABLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_s,
    input  logic lo_s,
    output logic bit_evt,
    output logic bit_val,
    output logic gap_evt,
    output logic line_err
);
    localparam int GAP_CLKS = 2 * BIT_CLKS;
    localparam int CNT_W    = $clog2(GAP_CLKS + 1);
    localparam int ST_W     = $clog2(MIN_STABLE + 1);
    localparam logic [CNT_W-1:0] GAP_FULL = CNT_W'(GAP_CLKS);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CLKS - 1);
    localparam logic [ST_W-1:0]  ST_LAST  = ST_W'(MIN_STABLE - 1);

    cell_state_t      state, nxt;
    logic [CNT_W-1:0] null_cnt;
    logic [ST_W-1:0]  stab_cnt;
    logic             lvl_hi;
    logic             bit_d, gap_d, err_d;
    logic             any_lvl, both_lvl;

    assign any_lvl  = hi_s | lo_s;
    assign both_lvl = hi_s & lo_s;

    always_comb begin
        nxt   = state;
        bit_d = 1'b0;
        gap_d = 1'b0;
        err_d = 1'b0;
        unique case (state)
            CELL_NULL: begin
                if (both_lvl) begin
                    err_d = 1'b1;
                    nxt   = CELL_FAULT;
                end else if (any_lvl) begin
                    nxt = CELL_QUAL;
                end else if (null_cnt == GAP_LAST) begin
                    gap_d = 1'b1;
                end
            end
            CELL_QUAL: begin
                if (both_lvl) begin
                    err_d = 1'b1;
                    nxt   = CELL_FAULT;
                end else if (!any_lvl) begin
                    nxt = CELL_NULL;
                end else if (hi_s == lvl_hi && stab_cnt == ST_LAST) begin
                    bit_d = 1'b1;
                    nxt   = CELL_HOLD;
                end
            end
            CELL_HOLD: begin
                if (both_lvl) begin
                    err_d = 1'b1;
                    nxt   = CELL_FAULT;
                end else if (!any_lvl) begin
                    nxt = CELL_NULL;
                end
            end
            CELL_FAULT: begin
                if (!any_lvl) begin
                    nxt = CELL_NULL;
                end
            end
            default: nxt = CELL_NULL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= CELL_NULL;
            null_cnt <= '0;
            stab_cnt <= '0;
            lvl_hi   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == CELL_NULL && !any_lvl) begin
                null_cnt <= (null_cnt == GAP_FULL) ? null_cnt : null_cnt + 1'b1;
            end else begin
                null_cnt <= '0;
            end
            if (state != CELL_QUAL || hi_s != lvl_hi) begin
                stab_cnt <= ST_W'(1);
                lvl_hi   <= hi_s;
            end else begin
                stab_cnt <= stab_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_evt  <= 1'b0;
            bit_val  <= 1'b0;
            gap_evt  <= 1'b0;
            line_err <= 1'b0;
        end else begin
            bit_evt  <= bit_d;
            bit_val  <= bit_d ? hi_s : bit_val;
            gap_evt  <= gap_d;
            line_err <= err_d;
        end
    end

    // Level seen for three samples in a row before a bit is accepted (default MIN_STABLE)
    assert_bit_needs_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_evt |-> ($past(hi_s, 1) == $past(hi_s, 2)) && ($past(hi_s, 2) == $past(hi_s, 3))
                    && ($past(hi_s, 1) != $past(lo_s, 1)));

    assert_bit_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_evt |-> bit_val == $past(hi_s));

    assert_gap_on_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gap_evt |-> $past(!hi_s && !lo_s));

    assert_fault_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_s && lo_s && state != CELL_FAULT) |=> line_err);
endmodule

// File: rtl/rz429_assemble.sv
module rz429_assemble
    import rz429_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_evt,
    input  logic                 bit_val,
    input  logic                 gap_evt,
    input  logic                 line_err,
    input  logic                 label_as_sent,
    output logic                 word_valid,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 parity_error,
    output logic                 length_error
);
    localparam int CNT_W = $clog2(WORD_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(WORD_BITS - 1);
    localparam logic [CNT_W-1:0] LABEL_CNT = CNT_W'(LABEL_BITS);
    localparam logic [CNT_W-1:0] LABEL_TOP = CNT_W'(LABEL_BITS - 1);

    asm_state_t           state, nxt;
    logic [CNT_W-1:0]     bit_cnt, cnt_d;
    logic [CNT_W-1:0]     idx;
    logic [WORD_BITS-1:0] shreg, nword, shown;
    logic                 load, emit, len_d;

    always_comb begin
        idx        = (bit_cnt < LABEL_CNT) ? (LABEL_TOP - bit_cnt) : bit_cnt;
        nword      = shreg;
        nword[idx] = bit_val;
        shown      = label_as_sent ? {nword[WORD_BITS-1:LABEL_BITS], flip_octet(nword[LABEL_BITS-1:0])}
                                   : nword;
    end

    always_comb begin
        nxt   = state;
        cnt_d = bit_cnt;
        load  = 1'b0;
        emit  = 1'b0;
        len_d = 1'b0;
        if (line_err) begin
            nxt   = ASM_DISCARD;
            cnt_d = '0;
        end else begin
            unique case (state)
                ASM_IDLE: begin
                    if (bit_evt) begin
                        load  = 1'b1;
                        cnt_d = CNT_W'(1);
                        nxt   = ASM_COLLECT;
                    end
                end
                ASM_COLLECT: begin
                    if (bit_evt) begin
                        load = 1'b1;
                        if (bit_cnt == CNT_LAST) begin
                            emit  = 1'b1;
                            cnt_d = '0;
                            nxt   = ASM_IDLE;
                        end else begin
                            cnt_d = bit_cnt + 1'b1;
                        end
                    end else if (gap_evt) begin
                        len_d = 1'b1;
                        cnt_d = '0;
                        nxt   = ASM_IDLE;
                    end
                end
                ASM_DISCARD: begin
                    if (gap_evt) begin
                        nxt = ASM_IDLE;
                    end
                end
                default: nxt = ASM_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ASM_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            state   <= nxt;
            bit_cnt <= cnt_d;
            if (load) begin
                shreg <= nword;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid   <= 1'b0;
            word_data    <= '0;
            parity_error <= 1'b0;
            length_error <= 1'b0;
        end else begin
            word_valid   <= emit;
            word_data    <= emit ? shown : word_data;
            parity_error <= emit & ~(^nword);
            length_error <= len_d;
        end
    end

    assert_valid_after_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(bit_evt));

    assert_valid_one_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_parity_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        parity_error |-> word_valid);

    assert_length_after_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        length_error |-> ($past(gap_evt) && !word_valid));

    assert_abort_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |=> !word_valid);
endmodule

// File: rtl/rz429_word_rx.sv
module rz429_word_rx
    import rz429_pkg::*;
#(
    parameter int BIT_CLKS    = 500,
    parameter int MIN_STABLE  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_hi,
    input  logic        line_lo,
    input  logic        label_as_sent,
    output logic        word_valid,
    output logic [31:0] word_data,
    output logic        parity_error,
    output logic        length_error,
    output logic        line_error
);
    logic [1:0] lines_s;
    logic       bit_evt, bit_val, gap_evt;

    rz429_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({line_hi, line_lo}),
        .dout (lines_s)
    );

    rz429_cell #(.BIT_CLKS(BIT_CLKS), .MIN_STABLE(MIN_STABLE)) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_s    (lines_s[1]),
        .lo_s    (lines_s[0]),
        .bit_evt (bit_evt),
        .bit_val (bit_val),
        .gap_evt (gap_evt),
        .line_err(line_error)
    );

    rz429_assemble u_asm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_evt      (bit_evt),
        .bit_val      (bit_val),
        .gap_evt      (gap_evt),
        .line_err     (line_error),
        .label_as_sent(label_as_sent),
        .word_valid   (word_valid),
        .word_data    (word_data),
        .parity_error (parity_error),
        .length_error (length_error)
    );
endmodule

// File: tb/test_rz429_word_rx.sv
`timescale 1ns/1ps
module test_rz429_word_rx;
    localparam int BIT_CLKS = 8;
    localparam int HALF     = BIT_CLKS / 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        line_hi, line_lo, label_as_sent;
    logic        word_valid, parity_error, length_error, line_error;
    logic [31:0] word_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expected event kinds: 0 word, 1 length error, 2 line error
    int          kq[$];
    logic [31:0] dq[$];
    logic        pq[$];
    string       rq[$];

    always #10 clk = ~clk;

    rz429_word_rx #(.BIT_CLKS(BIT_CLKS), .MIN_STABLE(3), .SYNC_STAGES(2)) i_rz429_word_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_hi      (line_hi),
        .line_lo      (line_lo),
        .label_as_sent(label_as_sent),
        .word_valid   (word_valid),
        .word_data    (word_data),
        .parity_error (parity_error),
        .length_error (length_error),
        .line_error   (line_error)
    );

    task automatic drive(input logic h, input logic l, input int n);
        line_hi = h;
        line_lo = l;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input int hold);
        drive(b, !b, hold);
        drive(1'b0, 1'b0, HALF);
    endtask

    // transmit the first nbits in line order; optional glitch after bit glitch_at, long level at long_at
    task automatic tx_bits(input logic [31:0] w, input int nbits, input int glitch_at, input int long_at);
        for (int k = 0; k < nbits; k++) begin
            int pos;
            pos = (k < 8) ? 7 - k : k;
            send_bit(w[pos], (k == long_at) ? 3 * BIT_CLKS : HALF);
            if (k == glitch_at) begin
                drive(1'b1, 1'b0, 2);
                drive(1'b0, 1'b0, HALF);
            end
        end
    endtask

    task automatic gap();
        drive(1'b0, 1'b0, 3 * BIT_CLKS);
    endtask

    task automatic push_word(input logic [31:0] w, input string req);
        logic [31:0] e;
        e = w;
        if (label_as_sent) begin
            for (int i = 0; i < 8; i++) e[i] = w[7 - i];
        end
        kq.push_back(0);
        dq.push_back(e);
        pq.push_back(~(^w));
        rq.push_back(req);
    endtask

    task automatic push_kind(input int k, input string req);
        kq.push_back(k);
        dq.push_back('0);
        pq.push_back(1'b0);
        rq.push_back(req);
    endtask

    task automatic expect_drained(input string req);
        checks++;
        if (kq.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d expected events outstanding, expected 0", req, kq.size());
        end
    endtask

    task automatic send_word(input logic [31:0] w, input string req);
        push_word(w, req);
        tx_bits(w, 32, -1, -1);
        gap();
        expect_drained(req);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin : monitor
        int          got, ek;
        logic [31:0] ed;
        logic        ep;
        string       er;
        if (rst_n && (word_valid || length_error || line_error)) begin
            got = word_valid ? 0 : (length_error ? 1 : 2);
            checks++;
            if (kq.size() == 0) begin
                fails++;
                $display("FAIL unexpected event: kind %0d data %h, expected no event", got, word_data);
            end else begin
                ek = kq.pop_front();
                ed = dq.pop_front();
                ep = pq.pop_front();
                er = rq.pop_front();
                if (got != ek || (got == 0 && (word_data != ed || parity_error != ep))) begin
                    fails++;
                    $display("FAIL %s: kind %0d data %h perr %0b, expected kind %0d data %h perr %0b",
                             er, got, word_data, parity_error, ek, ed, ep);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        line_hi = 1'b0;
        line_lo = 1'b0;
        label_as_sent = 1'b0;
        repeat (4) @(negedge clk);
        checks++;
        if ({word_valid, parity_error, length_error, line_error} != 4'b0000) begin
            fails++;
            $display("FAIL R11: flags %b, expected 0000", {word_valid, parity_error, length_error, line_error});
        end
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 30);

        // R2 / R3: label order and data order, natural presentation
        send_word(32'h8000_00D1, "R2");
        send_word(32'h5A3C_9617, "R3");
        // R1 / R5: extreme patterns and parity
        send_word(32'hFFFF_FFFF, "R1");
        send_word(32'h0000_0000, "R1");
        send_word(32'h0000_0001, "R5");
        send_word(32'h0000_0003, "R5");

        // R4: bit-reversed label presentation
        label_as_sent = 1'b1;
        send_word(32'h0000_008B, "R4");
        send_word(32'hA5A5_A5C3, "R4");
        label_as_sent = 1'b0;

        // R7: a short pulse in a null phase is ignored
        push_word(32'h1357_9BDF, "R7");
        tx_bits(32'h1357_9BDF, 32, 10, -1);
        gap();
        expect_drained("R7");
        push_word(32'h2468_ACE0, "R7");
        tx_bits(32'h2468_ACE0, 32, 3, -1);
        gap();
        expect_drained("R7");

        // R10: a level held three bit times counts once
        push_word(32'hC0FF_EE11, "R10");
        tx_bits(32'hC0FF_EE11, 32, -1, 3);
        gap();
        expect_drained("R10");

        // R6: back-to-back words, first reported before any gap
        push_word(32'h0F0F_1234, "R6");
        tx_bits(32'h0F0F_1234, 32, -1, -1);
        expect_drained("R6");
        push_word(32'hF0F0_4321, "R6");
        tx_bits(32'hF0F0_4321, 32, -1, -1);
        gap();
        expect_drained("R6");

        // R8: short word ended by a gap
        push_kind(1, "R8");
        tx_bits(32'hDEAD_BEEF, 12, -1, -1);
        gap();
        expect_drained("R8");
        push_kind(1, "R8");
        tx_bits(32'h1234_5678, 31, -1, -1);
        gap();
        expect_drained("R8");

        // R9: both inputs high aborts the word, later bits ignored until gap
        push_kind(2, "R9");
        tx_bits(32'hABCD_EF01, 10, -1, -1);
        drive(1'b1, 1'b1, HALF);
        drive(1'b0, 1'b0, HALF);
        tx_bits(32'hFFFF_FFFF, 5, -1, -1);
        gap();
        expect_drained("R9");
        send_word(32'h7654_3210, "R9");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule